// File: doc/BRIEF.md
# Binary Point Register Pair with Common-Mode Aliasing

This block holds the two 3-bit binary point values of an interrupt controller's virtual CPU interface: one for group 0 and one for group 1. A binary point value splits an 8-bit interrupt priority into an upper group-priority field, which decides preemption, and a lower subpriority field, which does not. The block also turns an incoming priority and its group into the preemption group priority under the binary point that is active for that group.

A common-mode control input chooses how group 1 gets its binary point. With common mode off, group 1 uses its own register. With common mode on, group 1 is tied to group 0. Register accesses that name group 1 are then redirected, and the result depends on whether the access is secure. A non-secure read returns the group-0 value plus one, saturated at 7. A non-secure write is dropped. A secure read returns the group-0 value, and a secure write lands in the group-0 register.

The number of implemented priority bits, `PRIO_W`, can be 5 to 7. It sets the smallest legal binary point, `MIN_BP = 7 - PRIO_W`. Implemented priority bits sit at the top of the 8-bit priority. The block has no state machine: it is two registers with the routing logic around them.

Top module: `bin_point_pair`

## Requirements
- R1: After reset, both binary point registers hold `MIN_BP` (2 when `PRIO_W` = 5).
- R2: A write takes effect at the next rising clock edge. While `rd_en` is high, `rd_data` gives the selected value in the same cycle. While `rd_en` is low, `rd_data` is 0. The select encoding for `wr_sel` and `rd_sel` is 0 for group 0 and 1 for group 1.
- R3: Any write value below `MIN_BP` is stored as `MIN_BP`.
- R4: With `common_en` low, group-1 reads and writes use the group-1 register. The secure input has no effect on them.
- R5: With `common_en` high, a non-secure group-1 read returns the group-0 value plus one, saturated at 7.
- R6: With `common_en` high, a non-secure group-1 write leaves both registers unchanged.
- R7: With `common_en` high, a secure group-1 read returns the group-0 value. A secure group-1 write updates the group-0 register and leaves the group-1 register unchanged.
- R8: `grp_prio` equals `prio_in` with bits [bp:0] cleared. For `prio_grp` = 0, bp is the group-0 value.
- R9: For `prio_grp` = 1, bp is the group-1 register when `common_en` is low. When `common_en` is high, bp is the group-0 value plus one, saturated at 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| common_en | input | 1 | Common-mode control: ties group 1 to group 0 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write register select (0 group 0, 1 group 1) |
| wr_secure | input | 1 | Write access is secure |
| wr_data | input | 3 | Write value |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read register select (0 group 0, 1 group 1) |
| rd_secure | input | 1 | Read access is secure |
| rd_data | output | 3 | Read value, valid in the strobe cycle |
| prio_in | input | 8 | Interrupt priority |
| prio_grp | input | 1 | Group of the priority (0 or 1) |
| grp_prio | output | 8 | Preemption group priority |

## Verification
Some properties are checked on every cycle. Both registers must stay at or above `MIN_BP`. A non-secure group-1 read in common mode must return the saturated increment of the group-0 register. A dropped non-secure write must leave both registers stable. A secure group-1 write in common mode must land in group 0. The group priority must never set a bit that is clear in the input priority. Other behaviours show up only in the bench's directed scenarios: the reset values, the same-cycle read timing, how group 1 keeps its own value while common mode toggles, and the exact masks at the saturation point.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
    localparam int BP_W = 3;
    localparam int PR_W = 8;

    typedef enum logic {
        BP_GRP0 = 1'b0,
        BP_GRP1 = 1'b1
    } bp_grp_e;

    function automatic logic [BP_W-1:0] bp_sat_inc(input logic [BP_W-1:0] v);
        return (v == {BP_W{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/bp_store.sv
module bp_store
    import bpr_pkg::*;
#(
    parameter logic [BP_W-1:0] MIN_BP = 3'd2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [BP_W-1:0] din,
    output logic [BP_W-1:0] q
);
    logic [BP_W-1:0] clamped;

    always_comb begin
        clamped = (din < MIN_BP) ? MIN_BP : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= MIN_BP;
        else if (we) q <= clamped;
    end
endmodule

// File: rtl/bp_alias_mux.sv
module bp_alias_mux
    import bpr_pkg::*;
(
    input  logic            common_en,
    input  logic [BP_W-1:0] bp0,
    input  logic [BP_W-1:0] bp1,
    input  logic            rd_en,
    input  bp_grp_e         rd_sel,
    input  logic            rd_secure,
    input  bp_grp_e         prio_grp,
    output logic [BP_W-1:0] rd_data,
    output logic [BP_W-1:0] eff_bp
);
    logic [BP_W-1:0] bp0_inc;
    logic [BP_W-1:0] g1_view;
    logic [BP_W-1:0] g1_eff;

    always_comb begin
        bp0_inc = bp_sat_inc(bp0);
        // Group-1 register view: secure sees group 0 itself, non-secure sees +1
        if (!common_en)     g1_view = bp1;
        else if (rd_secure) g1_view = bp0;
        else                g1_view = bp0_inc;
        g1_eff = common_en ? bp0_inc : bp1;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (rd_sel)
                BP_GRP0: rd_data = bp0;
                BP_GRP1: rd_data = g1_view;
                default: rd_data = '0;
            endcase
        end
        unique case (prio_grp)
            BP_GRP0: eff_bp = bp0;
            BP_GRP1: eff_bp = g1_eff;
            default: eff_bp = bp0;
        endcase
    end
endmodule

// File: rtl/bp_group_mask.sv
module bp_group_mask
    import bpr_pkg::*;
(
    input  logic [PR_W-1:0] prio_in,
    input  logic [BP_W-1:0] bp,
    output logic [PR_W-1:0] grp_prio
);
    logic [PR_W:0] low_mask;

    always_comb begin
        low_mask = ((PR_W+1)'(2) << bp) - (PR_W+1)'(1);
        grp_prio = prio_in & ~low_mask[PR_W-1:0];
    end
endmodule

// File: rtl/bin_point_pair.sv
module bin_point_pair
    import bpr_pkg::*;
#(
    parameter int PRIO_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       common_en,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic       wr_secure,
    input  logic [2:0] wr_data,
    input  logic       rd_en,
    input  logic       rd_sel,
    input  logic       rd_secure,
    output logic [2:0] rd_data,
    input  logic [7:0] prio_in,
    input  logic       prio_grp,
    output logic [7:0] grp_prio
);
    localparam logic [BP_W-1:0] MIN_BP = BP_W'(7 - PRIO_W);
    localparam int NGRP = 2;

    bp_grp_e         wsel;
    logic [NGRP-1:0] we;
    logic [BP_W-1:0] bp_q [NGRP];
    logic [BP_W-1:0] bp0_q;
    logic [BP_W-1:0] bp1_q;
    logic [BP_W-1:0] eff_bp;

    always_comb begin
        wsel  = bp_grp_e'(wr_sel);
        we[0] = wr_en && ((wsel == BP_GRP0) ||
                          (wsel == BP_GRP1 && common_en && wr_secure));
        we[1] = wr_en && (wsel == BP_GRP1) && !common_en;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_reg
        bp_store #(.MIN_BP(MIN_BP)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[g]),
            .din   (wr_data),
            .q     (bp_q[g])
        );
    end

    assign bp0_q = bp_q[0];
    assign bp1_q = bp_q[1];

    bp_alias_mux u_mux (
        .common_en (common_en),
        .bp0       (bp0_q),
        .bp1       (bp1_q),
        .rd_en     (rd_en),
        .rd_sel    (bp_grp_e'(rd_sel)),
        .rd_secure (rd_secure),
        .prio_grp  (bp_grp_e'(prio_grp)),
        .rd_data   (rd_data),
        .eff_bp    (eff_bp)
    );

    bp_group_mask u_mask (
        .prio_in  (prio_in),
        .bp       (eff_bp),
        .grp_prio (grp_prio)
    );
endmodule

// File: rtl/bin_point_pair_chk.sv
module bin_point_pair_chk #(
    parameter int PRIO_W = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       common_en,
    input logic       wr_en,
    input logic       wr_sel,
    input logic       wr_secure,
    input logic [2:0] wr_data,
    input logic       rd_en,
    input logic       rd_sel,
    input logic       rd_secure,
    input logic [2:0] rd_data,
    input logic [7:0] prio_in,
    input logic [7:0] grp_prio,
    input logic [2:0] bp0_q,
    input logic [2:0] bp1_q
);
    localparam logic [2:0] MINV = 3'(7 - PRIO_W);

    AST_REG_ABOVE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (bp0_q >= MINV) && (bp1_q >= MINV)); // R3

    AST_NS_READ_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (common_en && rd_en && rd_sel && !rd_secure) |->
        (rd_data == ((bp0_q == 3'd7) ? 3'd7 : bp0_q + 3'd1))); // R5

    AST_NS_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (common_en && wr_en && wr_sel && !wr_secure) |=>
        ($stable(bp0_q) && $stable(bp1_q))); // R6

    AST_S_WRITE_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (common_en && wr_en && wr_sel && wr_secure && wr_data >= MINV) |=>
        (bp0_q == $past(wr_data) && $stable(bp1_q))); // R7

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == 3'd0)); // R2

    AST_GRP_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_prio & ~prio_in) == 8'd0)); // R8
endmodule

bind bin_point_pair bin_point_pair_chk #(.PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .common_en (common_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_secure (wr_secure),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .rd_secure (rd_secure),
    .rd_data   (rd_data),
    .prio_in   (prio_in),
    .grp_prio  (grp_prio),
    .bp0_q     (bp0_q),
    .bp1_q     (bp1_q)
);

// File: tb/tb_bin_point_pair.sv
module tb_bin_point_pair;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       common_en = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, wr_secure = 1'b0;
    logic [2:0] wr_data = 3'd0;
    logic       rd_en = 1'b0, rd_sel = 1'b0, rd_secure = 1'b0;
    logic [2:0] rd_data;
    logic [7:0] prio_in = 8'd0;
    logic       prio_grp = 1'b0;
    logic [7:0] grp_prio;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    bin_point_pair #(.PRIO_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .common_en(common_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_secure(wr_secure), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_secure(rd_secure), .rd_data(rd_data),
        .prio_in(prio_in), .prio_grp(prio_grp), .grp_prio(grp_prio)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic sec, input logic [2:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_secure = sec; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic sel, input logic sec, input int exp);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel; rd_secure = sec;
        #1;
        check(req, int'(rd_data), exp);
        rd_en = 1'b0;
    endtask

    task automatic gp_check(input string req, input logic grp, input logic [7:0] p, input int exp);
        @(negedge clk);
        prio_grp = grp; prio_in = p;
        #1;
        check(req, int'(grp_prio), exp);
    endtask

    task automatic t_reset;
        rd_check("R1 g0 reset", 1'b0, 1'b0, 2);
        rd_check("R1 g1 reset", 1'b1, 1'b0, 2);
    endtask

    task automatic t_basic;
        wr(1'b0, 1'b0, 3'd4);
        rd_check("R2 g0 write", 1'b0, 1'b0, 4);
        @(negedge clk); rd_sel = 1'b0; #1;
        check("R2 idle read zero", int'(rd_data), 0);
    endtask

    task automatic t_clamp;
        wr(1'b0, 1'b0, 3'd0);
        rd_check("R3 g0 clamp", 1'b0, 1'b0, 2);
        wr(1'b1, 1'b1, 3'd1);
        rd_check("R3 g1 clamp", 1'b1, 1'b1, 2);
    endtask

    task automatic t_separate;
        common_en = 1'b0;
        wr(1'b1, 1'b0, 3'd5);
        rd_check("R4 g1 ns read", 1'b1, 1'b0, 5);
        rd_check("R4 g1 s read", 1'b1, 1'b1, 5);
        rd_check("R4 g0 untouched", 1'b0, 1'b0, 2);
    endtask

    task automatic t_common_ns;
        wr(1'b0, 1'b0, 3'd4);
        common_en = 1'b1;
        rd_check("R5 ns read plus one", 1'b1, 1'b0, 5);
        wr(1'b0, 1'b0, 3'd7);
        rd_check("R5 ns read saturate", 1'b1, 1'b0, 7);
        wr(1'b1, 1'b0, 3'd3);
        rd_check("R6 g0 unchanged", 1'b0, 1'b0, 7);
        common_en = 1'b0;
        rd_check("R6 g1 unchanged", 1'b1, 1'b0, 5);
    endtask

    task automatic t_common_s;
        common_en = 1'b1;
        wr(1'b1, 1'b1, 3'd3);
        rd_check("R7 secure write to g0", 1'b0, 1'b0, 3);
        rd_check("R7 secure read g0 value", 1'b1, 1'b1, 3);
        common_en = 1'b0;
        rd_check("R7 g1 kept", 1'b1, 1'b0, 5);
    endtask

    task automatic t_grp_prio;
        common_en = 1'b0;
        gp_check("R8 g0 bp3", 1'b0, 8'hFF, 8'hF0);
        wr(1'b0, 1'b0, 3'd2);
        gp_check("R8 g0 bp2", 1'b0, 8'hA5, 8'hA0);
        gp_check("R9 g1 own bp5", 1'b1, 8'hFF, 8'hC0);
        wr(1'b0, 1'b0, 3'd3);
        common_en = 1'b1;
        gp_check("R9 g1 common bp4", 1'b1, 8'hFF, 8'hE0);
        wr(1'b0, 1'b0, 3'd7);
        gp_check("R9 g1 common sat", 1'b1, 8'hFF, 8'h00);
        common_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_basic();
        t_clamp();
        t_separate();
        t_common_ns();
        t_common_s();
        t_grp_prio();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule